// File: doc/BRIEF.md
# Pretrigger/Posttrigger Acquisition Sequencer

This block runs one recording window of a sampling digitizer, measured in sample-clock cycles. A start pulse clears the completion flag and opens the window: the sample memory write enable goes high at once, while trigger inputs are held off for a programmable number of cycles. This hold-off gives the memory time to fill with history from before the event.

After the hold-off the sequencer is armed and waits for a trigger. The trigger can be the bus software trigger, or the external trigger when its enable is set. Once a trigger is taken, a second programmable count runs. When that count ends, the write enable drops and the completion flag is raised. The flag stays up until the next start or a board reset command.

Both delay values are 16-bit inputs from the register file. Typical defaults are 10240 cycles of hold-off and 64 cycles after the trigger. The hold-off value is captured at start, and the post-trigger value is captured when the trigger is taken.

Top module: `acq_seq`

## Requirements
- R1: While rst_ni is low and after it is released, wr_en_o, armed_o and irq_o are all 0.
- R2: A start pulse without a reset command clears irq_o. In the cycle after the start edge wr_en_o is 1 and armed_o is 0.
- R3: The hold-off value N is sampled at the start edge. armed_o rises exactly N clock edges after the start edge. A value of 0 behaves as 1.
- R4: sw_trig_i and ext_trig_i pulses during the hold-off are ignored. They do not change the edge at which armed_o rises.
- R5: While armed, a trigger sampled at a clock edge drops armed_o after that edge while wr_en_o stays 1. The post-trigger value M is sampled at that edge. wr_en_o falls exactly M edges after the trigger edge, and 0 behaves as 1.
- R6: irq_o rises in the same cycle that wr_en_o falls at the end of a window. It then holds at 1 until a start or a reset command.
- R7: ext_trig_i counts as a trigger only when ext_trig_en_i is 1. sw_trig_i always counts.
- R8: reset_cmd_i returns the block to idle: wr_en_o, armed_o and irq_o are 0 after the edge. It takes priority over a start in the same cycle.
- R9: A start during a running window (hold-off, armed or post-trigger) restarts the hold-off from the new sampled value and clears irq_o.
- R10: While armed, the block waits for a trigger with no time limit. Triggers in idle open no window: wr_en_o and irq_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_cmd_i | input | 1 | Board reset command pulse, back to idle |
| start_i | input | 1 | Start acquisition command pulse |
| sw_trig_i | input | 1 | Software trigger pulse from the bus |
| ext_trig_i | input | 1 | External trigger, already edge-detected |
| ext_trig_en_i | input | 1 | Enable for the external trigger |
| pretrig_i | input | 16 | Hold-off length in clock cycles |
| posttrig_i | input | 16 | Post-trigger length in clock cycles |
| wr_en_o | output | 1 | Sample memory write enable |
| armed_o | output | 1 | High while triggers are accepted |
| irq_o | output | 1 | Acquisition complete flag |

## Verification
The bench builds the block with the default 16-bit counter width, so the delay registers keep their full range. Most windows use small delays (0, 1, 2, 3, 5), which puts the zero-as-one rule, the single-cycle windows and restarts in the middle of a count within a few cycles. One window runs with the typical 10240/64 values to show that the long hold-off count lands on the exact edge.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } acq_state_e;
endpackage

// File: rtl/acq_dcnt.sv
module acq_dcnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  // zero and one both end the phase
  assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reset_cmd_i,
  input  logic       start_i,
  input  logic       trig_i,
  input  logic       cnt_last_i,
  output logic       ld_pre_o,
  output logic       ld_post_o,
  output logic       dec_o,
  output acq_state_e state_o,
  output logic       irq_o
);
  acq_state_e state_q, state_d;
  logic       irq_q, irq_d;

  always_comb begin
    state_d   = state_q;
    irq_d     = irq_q;
    ld_pre_o  = 1'b0;
    ld_post_o = 1'b0;
    dec_o     = 1'b0;
    if (reset_cmd_i) begin
      state_d = ST_IDLE;
      irq_d   = 1'b0;
    end else if (start_i) begin
      state_d  = ST_PRE;
      irq_d    = 1'b0;
      ld_pre_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_PRE: begin
          if (cnt_last_i) state_d = ST_ARMED;
          else            dec_o   = 1'b1;
        end
        ST_ARMED: begin
          if (trig_i) begin
            state_d   = ST_POST;
            ld_post_o = 1'b1;
          end
        end
        ST_POST: begin
          if (cnt_last_i) begin
            state_d = ST_DONE;
            irq_d   = 1'b1;
          end else begin
            dec_o = 1'b1;
          end
        end
        ST_DONE: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign state_o = state_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_cmd_i,
  input  logic             start_i,
  input  logic             sw_trig_i,
  input  logic             ext_trig_i,
  input  logic             ext_trig_en_i,
  input  logic [CNT_W-1:0] pretrig_i,
  input  logic [CNT_W-1:0] posttrig_i,
  output logic             wr_en_o,
  output logic             armed_o,
  output logic             irq_o
);
  logic             trig, ld_pre, ld_post, dec, cnt_last;
  logic [CNT_W-1:0] load_val;
  acq_state_e       state;

  assign trig     = sw_trig_i | (ext_trig_i & ext_trig_en_i);
  assign load_val = ld_pre ? pretrig_i : posttrig_i;

  acq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reset_cmd_i(reset_cmd_i),
    .start_i    (start_i),
    .trig_i     (trig),
    .cnt_last_i (cnt_last),
    .ld_pre_o   (ld_pre),
    .ld_post_o  (ld_post),
    .dec_o      (dec),
    .state_o    (state),
    .irq_o      (irq_o)
  );

  // one counter serves both phases; they never overlap
  acq_dcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ld_pre | ld_post),
    .load_val_i(load_val),
    .dec_i     (dec),
    .last_o    (cnt_last)
  );

  assign armed_o = (state == ST_ARMED);
  assign wr_en_o = (state == ST_PRE) || (state == ST_ARMED) || (state == ST_POST);
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reset_cmd_i,
  input logic             start_i,
  input logic             sw_trig_i,
  input logic             ext_trig_i,
  input logic             ext_trig_en_i,
  input logic [CNT_W-1:0] pretrig_i,
  input logic             wr_en_o,
  input logic             armed_o,
  input logic             irq_o
);
  logic [CNT_W:0] since_q, need_q;
  logic           trig;

  assign trig = sw_trig_i | (ext_trig_i & ext_trig_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      need_q  <= '0;
    end else if (start_i && !reset_cmd_i) begin
      since_q <= '0;
      need_q  <= (pretrig_i == '0) ? (CNT_W+1)'(1) : {1'b0, pretrig_i};
    end else if (since_q != '1) begin
      since_q <= since_q + (CNT_W+1)'(1);
    end
  end

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !reset_cmd_i) |=> (!irq_o && wr_en_o && !armed_o));

  a_r3_arm_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> (since_q == need_q));

  a_r5_trig_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && trig && !start_i && !reset_cmd_i) |=> (!armed_o && wr_en_o));

  a_r6_irq_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(wr_en_o) && !$past(reset_cmd_i)) |-> irq_o);

  a_r8_reset_cmd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_cmd_i |=> (!wr_en_o && !armed_o && !irq_o));
endmodule

bind acq_seq acq_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reset_cmd_i  (reset_cmd_i),
  .start_i      (start_i),
  .sw_trig_i    (sw_trig_i),
  .ext_trig_i   (ext_trig_i),
  .ext_trig_en_i(ext_trig_en_i),
  .pretrig_i    (pretrig_i),
  .wr_en_o      (wr_en_o),
  .armed_o      (armed_o),
  .irq_o        (irq_o)
);

// File: tb/sim_acq_seq.sv
`timescale 1ns/1ps
module sim_acq_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reset_cmd_i = 1'b0, start_i = 1'b0, sw_trig_i = 1'b0;
  logic        ext_trig_i = 1'b0, ext_trig_en_i = 1'b0;
  logic [15:0] pretrig_i = '0, posttrig_i = '0;
  logic        wr_en_o, armed_o, irq_o;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2 clk_i = ~clk_i;

  acq_seq u0 (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic start_acq(int pre, string req);
    pretrig_i = 16'(pre);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(req, "wr_en after start", int'(wr_en_o), 1);
    chk(req, "armed after start", int'(armed_o), 0);
    chk(req, "irq after start", int'(irq_o), 0);
  endtask

  task automatic wait_arm(int pre, string req);
    for (int k = 1; k <= eff(pre); k++) begin
      tick();
      chk(req, "armed timing", int'(armed_o), int'(k == eff(pre)));
    end
  endtask

  task automatic fire_post(int post, bit use_sw);
    posttrig_i = 16'(post);
    if (use_sw) sw_trig_i = 1'b1;
    else begin ext_trig_i = 1'b1; ext_trig_en_i = 1'b1; end
    tick();
    sw_trig_i = 1'b0; ext_trig_i = 1'b0; ext_trig_en_i = 1'b0;
    chk("R5", "armed after trigger", int'(armed_o), 0);
    chk("R5", "wr_en after trigger", int'(wr_en_o), 1);
    for (int k = 1; k <= eff(post); k++) begin
      tick();
      chk("R5", "wr_en post count", int'(wr_en_o), int'(k < eff(post)));
      chk("R6", "irq at stop", int'(irq_o), int'(k == eff(post)));
    end
  endtask

  task automatic t_reset();
    chk("R1", "wr_en in reset", int'(wr_en_o), 0);
    chk("R1", "irq in reset", int'(irq_o), 0);
    tick(); rst_ni = 1'b1; tick();
    chk("R1", "armed after reset", int'(armed_o), 0);
    chk("R1", "wr_en after reset", int'(wr_en_o), 0);
  endtask

  task automatic t_basic(int pre, int post, bit use_sw);
    start_acq(pre, "R2");
    wait_arm(pre, "R3");
    fire_post(post, use_sw);
  endtask

  task automatic t_irq_hold();
    repeat (5) tick();
    chk("R6", "irq held", int'(irq_o), 1);
    chk("R6", "wr_en idle", int'(wr_en_o), 0);
  endtask

  task automatic t_pre_ignore();
    start_acq(5, "R2");
    for (int k = 1; k <= 5; k++) begin
      if (k == 2) begin sw_trig_i = 1'b1; ext_trig_i = 1'b1; ext_trig_en_i = 1'b1; end
      tick();
      sw_trig_i = 1'b0; ext_trig_i = 1'b0; ext_trig_en_i = 1'b0;
      chk("R4", "armed despite early trig", int'(armed_o), int'(k == 5));
    end
    repeat (6) tick();
    chk("R10", "still armed", int'(armed_o), 1);
    chk("R10", "still writing", int'(wr_en_o), 1);
    fire_post(3, 1'b1);
  endtask

  task automatic t_ext_gate();
    start_acq(2, "R2");
    wait_arm(2, "R3");
    ext_trig_i = 1'b1; ext_trig_en_i = 1'b0;
    tick();
    ext_trig_i = 1'b0;
    chk("R7", "ext disabled keeps armed", int'(armed_o), 1);
    fire_post(2, 1'b0);
  endtask

  task automatic t_restart();
    start_acq(4, "R9");
    tick(); tick();
    start_acq(4, "R9");
    wait_arm(4, "R9");
    posttrig_i = 16'd6; sw_trig_i = 1'b1;
    tick(); sw_trig_i = 1'b0;
    tick();
    start_acq(2, "R9");
    chk("R9", "armed after restart in post", int'(armed_o), 0);
    wait_arm(2, "R9");
    fire_post(1, 1'b1);
  endtask

  task automatic t_reset_cmd();
    start_acq(3, "R2");
    tick();
    reset_cmd_i = 1'b1; start_i = 1'b1;
    tick();
    reset_cmd_i = 1'b0; start_i = 1'b0;
    chk("R8", "wr_en after reset cmd", int'(wr_en_o), 0);
    chk("R8", "armed after reset cmd", int'(armed_o), 0);
    t_basic(1, 1, 1'b1);
    reset_cmd_i = 1'b1;
    tick();
    reset_cmd_i = 1'b0;
    chk("R8", "irq cleared by reset cmd", int'(irq_o), 0);
  endtask

  task automatic t_idle_trig();
    sw_trig_i = 1'b1; ext_trig_i = 1'b1; ext_trig_en_i = 1'b1;
    tick();
    sw_trig_i = 1'b0; ext_trig_i = 1'b0; ext_trig_en_i = 1'b0;
    repeat (3) tick();
    chk("R10", "idle trig no wr_en", int'(wr_en_o), 0);
    chk("R10", "idle trig no irq", int'(irq_o), 0);
    chk("R10", "idle trig no armed", int'(armed_o), 0);
  endtask

  initial begin
    t_reset();
    t_basic(3, 2, 1'b1);
    t_irq_hold();
    t_basic(1, 1, 1'b0);
    t_basic(0, 0, 1'b1);
    t_pre_ignore();
    t_ext_gate();
    t_restart();
    t_reset_cmd();
    t_idle_trig();
    t_basic(10240, 64, 1'b1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule